// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the general-purpose integer registers of a processor core. Software sees 32 registers, numbered 0 to 31, in four groups of eight: globals (0–7), outs (8–15), locals (16–23) and ins (24–31). The block maps each register number onto a physical entry, using a window pointer that moves one step on each save command and one step back on each restore command. Each window has its own eight locals. The outs of window N share physical storage with the ins of window N+1, wrapping modulo the window count. A caller therefore leaves arguments in its outs, issues a save, and the callee finds them in its ins. No data is copied.

Two counters track window use. One counts the windows still free for a save. The other counts the windows a restore may return to. A save with no free window raises a spill request. A restore with nothing to return to raises a fill request. In both cases the pointer and counters stay where they are, so a trap handler can act. A command classifier picks one operation per cycle. The operations are IDLE (no command), SAVE (save with a free window), RESTORE (restore with a window to return to), SPILL (save with no free window) and FILL (restore with no window to return to). SAVE moves the pointer forward and shifts one count from the free counter to the returnable counter. RESTORE does the reverse. SPILL, FILL and IDLE change no state. The window count `NWIN` is a power of two between 2 and 32. The other-windows count of the architecture is held at zero here.

Top module: `winreg_file`

## Requirements
- R1: Registers 0–7 address one global set that is shared by every window. A value written to a global in one window reads back unchanged after any save or restore.
- R2: Register 0 always reads as zero on both read ports. A write to register 0 is discarded.
- R3: A successful save increments the window pointer modulo `NWIN`, decrements the free-window counter and increments the returnable counter, all on the next clock edge.
- R4: A successful restore decrements the window pointer modulo `NWIN`, increments the free-window counter and decrements the returnable counter, all on the next clock edge.
- R5: A save while the free-window counter is 0 raises `spill_req` in the same cycle. The pointer and both counters keep their values.
- R6: A restore while the returnable counter is 0 raises `fill_req` in the same cycle. The pointer and both counters keep their values.
- R7: In every cycle after reset, the free-window count plus the returnable count equals `NWIN` − 2.
- R8: The outs (8–15) of window w are the same storage as the ins (24–31) of window (w+1) mod `NWIN`. The locals (16–23) of each window are private to it.
- R9: After reset the window pointer is 0, the free-window counter is `NWIN` − 2, the returnable counter is 0 and every register reads as zero.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R11: When save and restore are asserted together, only the save is acted on. The restore is ignored and raises no fill request.
- R12: A write uses the window pointer of its own cycle, even when a save in that same cycle moves the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | DW | Read port A data (combinational) |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number to write |
| wr_data | input | DW | Write data |
| save_cmd | input | 1 | Move to the next window |
| restore_cmd | input | 1 | Move back to the previous window |
| spill_req | output | 1 | Save found no free window |
| fill_req | output | 1 | Restore found no window to return to |
| cwp_o | output | log2(NWIN) | Current window pointer |
| cansave_o | output | log2(NWIN)+1 | Free-window counter |
| canrestore_o | output | log2(NWIN)+1 | Returnable-window counter |

## Verification
The assertions assume that the commands arrive only from a clean reset state, and that nothing outside the block edits the counters. Under that assumption the free-window and returnable counts always sum to `NWIN` − 2. The bench reaches every window that is legal from reset by issuing saves until it gets a spill request, and then restores until it gets a fill request. It never issues a command that these rules forbid. It fills every global, out and local group with values computed from the window number and register number. It then checks the overlap of outs and ins, the privacy of the locals and the values of the counters arithmetically at each step.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    // one operation per cycle, chosen from the command inputs and the counters
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_SAVE    = 3'd1,
        OP_RESTORE = 3'd2,
        OP_SPILL   = 3'd3,
        OP_FILL    = 3'd4
    } win_op_e;

    localparam int GLOBALS = 8;
    localparam int PER_WIN = 16;

endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate #(
    parameter int NWIN = 8,
    localparam int WW   = $clog2(NWIN),
    localparam int PHYS = winreg_pkg::GLOBALS + winreg_pkg::PER_WIN * NWIN,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic [WW-1:0] cwp,
    input  logic [4:0]    arch,
    output logic [PW-1:0] phys
);
    logic [WW-1:0] nxt;
    logic [2:0]    off;

    assign nxt = cwp + 1'b1;
    assign off = arch[2:0];

    // physical layout: globals first, then per window {locals, ins}
    always_comb begin
        unique case (arch[4:3])
            2'd0: phys = PW'(arch);
            2'd1: phys = PW'(winreg_pkg::GLOBALS) + PW'({nxt, 4'b1000}) + PW'(off);
            2'd2: phys = PW'(winreg_pkg::GLOBALS) + PW'({cwp, 4'b0000}) + PW'(off);
            default: phys = PW'(winreg_pkg::GLOBALS) + PW'({cwp, 4'b1000}) + PW'(off);
        endcase
    end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int PHYS = 136,
    parameter int DW   = 32,
    localparam int PW  = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_addr,
    input  logic [PW-1:0] rb_addr,
    input  logic          w_en,
    input  logic [PW-1:0] w_addr,
    input  logic [DW-1:0] w_data,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] mem [PHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else if (w_en && (w_addr != '0)) begin
            mem[w_addr] <= w_data;
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : mem[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : mem[rb_addr];
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WW  = $clog2(NWIN),
    localparam int CW  = WW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_cmd,
    input  logic          restore_cmd,
    output logic [WW-1:0] cwp,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic          spill_req,
    output logic          fill_req
);
    win_op_e op;

    // classifier: save wins over restore
    always_comb begin
        if (save_cmd)
            op = (cansave == '0) ? OP_SPILL : OP_SAVE;
        else if (restore_cmd)
            op = (canrestore == '0) ? OP_FILL : OP_RESTORE;
        else
            op = OP_IDLE;
    end

    // state register: pointer and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp        <= '0;
            cansave    <= CW'(NWIN - 2);
            canrestore <= '0;
        end else begin
            unique case (op)
                OP_SAVE: begin
                    cwp        <= cwp + 1'b1;
                    cansave    <= cansave - 1'b1;
                    canrestore <= canrestore + 1'b1;
                end
                OP_RESTORE: begin
                    cwp        <= cwp - 1'b1;
                    cansave    <= cansave + 1'b1;
                    canrestore <= canrestore - 1'b1;
                end
                OP_IDLE, OP_SPILL, OP_FILL: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spill_req = 1'b0;
        fill_req  = 1'b0;
        unique case (op)
            OP_SPILL: spill_req = 1'b1;
            OP_FILL:  fill_req  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int WW   = $clog2(NWIN),
    localparam int CW   = WW + 1,
    localparam int PHYS = winreg_pkg::GLOBALS + winreg_pkg::PER_WIN * NWIN,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [4:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [4:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          save_cmd,
    input  logic          restore_cmd,
    output logic          spill_req,
    output logic          fill_req,
    output logic [WW-1:0] cwp_o,
    output logic [CW-1:0] cansave_o,
    output logic [CW-1:0] canrestore_o
);
    logic [4:0]    arch_idx [3];
    logic [PW-1:0] phys_idx [3];

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    winreg_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .save_cmd(save_cmd), .restore_cmd(restore_cmd),
        .cwp(cwp_o), .cansave(cansave_o), .canrestore(canrestore_o),
        .spill_req(spill_req), .fill_req(fill_req)
    );

    for (genvar g = 0; g < 3; g++) begin : g_xlate
        winreg_xlate #(.NWIN(NWIN)) u_xl (
            .cwp(cwp_o), .arch(arch_idx[g]), .phys(phys_idx[g])
        );
    end

    winreg_store #(.PHYS(PHYS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(phys_idx[0]), .rb_addr(phys_idx[1]),
        .w_en(wr_en), .w_addr(phys_idx[2]), .w_data(wr_data),
        .ra_data(rd_a_data), .rb_data(rd_b_data)
    );
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    localparam int WW  = $clog2(NWIN),
    localparam int CW  = WW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    rd_a_idx,
    input logic [DW-1:0] rd_a_data,
    input logic [4:0]    rd_b_idx,
    input logic [DW-1:0] rd_b_data,
    input logic          save_cmd,
    input logic          restore_cmd,
    input logic          spill_req,
    input logic          fill_req,
    input logic [WW-1:0] cwp_o,
    input logic [CW-1:0] cansave_o,
    input logic [CW-1:0] canrestore_o
);
    p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
    p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
    p_save_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_cmd && !spill_req) |=> (cwp_o == WW'($past(cwp_o) + 1'b1))
            && (cansave_o == CW'($past(cansave_o) - 1'b1)));
    p_restore_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_cmd && restore_cmd && !fill_req) |=> (cwp_o == WW'($past(cwp_o) - 1'b1))
            && (canrestore_o == CW'($past(canrestore_o) - 1'b1)));
    p_spill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spill_req |=> $stable(cwp_o) && $stable(cansave_o) && $stable(canrestore_o));
    p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> $stable(cwp_o) && $stable(cansave_o) && $stable(canrestore_o));
    p_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cansave_o) + int'(canrestore_o)) == (NWIN - 2));
    p_one_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spill_req, fill_req}));
    p_save_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (save_cmd && restore_cmd) |-> !fill_req);
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .save_cmd(save_cmd), .restore_cmd(restore_cmd),
    .spill_req(spill_req), .fill_req(fill_req),
    .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o)
);

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;
    localparam int NWIN = 8;
    localparam int DW   = 32;
    localparam int WW   = $clog2(NWIN);
    localparam int CW   = WW + 1;
    localparam int TOP  = NWIN - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic wr_en = 1'b0, save_cmd = 1'b0, restore_cmd = 1'b0;
    logic spill_req, fill_req;
    logic [WW-1:0] cwp_o;
    logic [CW-1:0] cansave_o, canrestore_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    winreg_file #(.NWIN(NWIN), .DW(DW)) dut (.*);

    function automatic logic [31:0] pat(int kind, int w, int i);
        return 32'h1000_0000 * kind + 32'(w * 256 + i + 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] va, output logic [31:0] vb);
        rd_a_idx = idx; rd_b_idx = idx;
        #0.5;
        va = rd_a_data; vb = rd_b_data;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] v);
        wr_en = 1'b1; wr_idx = idx; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic cmd(input bit s, input bit r, output bit sp, output bit fl);
        save_cmd = s; restore_cmd = r;
        #0.5;
        sp = spill_req; fl = fill_req;
        @(posedge clk); #1;
        save_cmd = 1'b0; restore_cmd = 1'b0;
    endtask

    task automatic chk_state(input string tag, input int w, input int cs, input int cr);
        check({tag, " cwp"}, 32'(cwp_o), 32'(w));
        check({tag, " cansave"}, 32'(cansave_o), 32'(cs));
        check({tag, " canrestore"}, 32'(canrestore_o), 32'(cr));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, vb;
        bit sp, fl;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset state
        chk_state("R9 reset", 0, TOP, 0);
        for (int i = 0; i < 32; i++) begin
            rd(5'(i), va, vb);
            check("R9 reg zero A", va, 32'h0);
            check("R9 reg zero B", vb, 32'h0);
        end

        // R2: r0 write discarded
        wr(5'd0, 32'hDEAD_BEEF);
        rd(5'd0, va, vb);
        check("R2 r0 port A", va, 32'h0);
        check("R2 r0 port B", vb, 32'h0);

        // R1: globals
        for (int i = 1; i < 8; i++) wr(5'(i), pat(3, 0, i));

        // descend: fill windows, save until spill
        for (int w = 0; w <= TOP; w++) begin
            for (int i = 0; i < 8; i++) begin
                wr(5'(16 + i), pat(1, w, i));
                wr(5'(8 + i), pat(2, w, i));
            end
            if (w < TOP) begin
                cmd(1'b1, 1'b0, sp, fl);
                check("R3 no spill", 32'(sp), 32'h0);
                chk_state("R3 R7 save", w + 1, TOP - w - 1, w + 1);
                for (int i = 0; i < 8; i++) begin
                    rd(5'(24 + i), va, vb);
                    check("R8 ins equal caller outs", va, pat(2, w, i));
                end
                for (int i = 1; i < 8; i++) begin
                    rd(5'(i), va, vb);
                    check("R1 global shared", vb, pat(3, 0, i));
                end
            end else begin
                cmd(1'b1, 1'b0, sp, fl);
                check("R5 spill raised", 32'(sp), 32'h1);
                chk_state("R5 spill hold", TOP, 0, TOP);
            end
        end

        // ascend: verify private locals and outs, restore until fill
        for (int w = TOP; w >= 0; w--) begin
            for (int i = 0; i < 8; i++) begin
                rd(5'(16 + i), va, vb);
                check("R8 local private", va, pat(1, w, i));
                rd(5'(8 + i), va, vb);
                check("R8 outs kept", vb, pat(2, w, i));
            end
            cmd(1'b0, 1'b1, sp, fl);
            if (w > 0) begin
                check("R4 no fill", 32'(fl), 32'h0);
                chk_state("R4 R7 restore", w - 1, TOP - w + 1, w - 1);
            end else begin
                check("R6 fill raised", 32'(fl), 32'h1);
                chk_state("R6 fill hold", 0, TOP, 0);
            end
        end
        for (int i = 1; i < 8; i++) begin
            rd(5'(i), va, vb);
            check("R1 global after restores", va, pat(3, 0, i));
        end

        // R10: read during write
        rd_a_idx = 5'd16; rd_b_idx = 5'd16;
        wr_en = 1'b1; wr_idx = 5'd16; wr_data = 32'h5A5A_0001;
        #0.5;
        check("R10 old value in write cycle", rd_a_data, pat(1, 0, 0));
        @(posedge clk); #1;
        wr_en = 1'b0;
        check("R10 new value after edge", rd_a_data, 32'h5A5A_0001);

        // R11: save and restore together at cwp 0, canrestore 0
        cmd(1'b1, 1'b1, sp, fl);
        check("R11 no fill", 32'(fl), 32'h0);
        check("R11 no spill", 32'(sp), 32'h0);
        chk_state("R11 save taken", 1, TOP - 1, 1);

        // R12: write with concurrent save lands in old window
        wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'hC0FF_EE01;
        cmd(1'b1, 1'b0, sp, fl);
        wr_en = 1'b0;
        chk_state("R12 R3 save", 2, TOP - 2, 2);
        rd(5'd17, va, vb);
        check("R12 new window untouched", va, pat(1, 2, 1));
        cmd(1'b0, 1'b1, sp, fl);
        rd(5'd17, va, vb);
        check("R12 write in old window", va, 32'hC0FF_EE01);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule